// File: doc/BRIEF.md
# Video Measurement Window Mask Generator

This block turns a raw pixel stream into a per-pixel "collect" qualifier for a downstream measurement engine. It hides the pixels that sit close to the horizontal and vertical sync events, so that accumulated statistics ignore blanking intervals and the vertical-interval data lines. Four regions are masked: a band of pixels just after each horizontal sync, a band just before the next one, a group of lines just after each vertical sync, and a group of lines just before the next vertical sync.

The two "before the next sync" regions cannot be known in advance, so the block learns them. Every horizontal sync captures the length of the line that just ended, and every vertical sync captures the line count of the frame that just ended. The masks for the current line and frame are then placed using those lengths. Each sync input has its own polarity select. The amount of vertical masking is picked from two 3-bit codes that map to line counts suited to common video timings. The amount of horizontal masking is given as two 8-bit pixel-pair counts.

Each of the two length trackers runs a three-state machine. `TRK_IDLE` waits for the first sync edge. The first edge moves it to `TRK_FIRST`, where it is counting its first complete interval. The second edge moves it to `TRK_LOCKED`, where a length is held. It stays in `TRK_LOCKED` until reset. The output is allowed high only while both trackers are in `TRK_LOCKED`.

Top module: `vmask_top`

## Requirements
- R1: The vertical post-sync code `vpost_sel` selects how many lines are masked starting at the line that holds the VSYNC active edge (that line is index 0). The mapping is 0→5, 1→18, 2→19, 3→20, 4→22, 5→25, 6→41 and 7→44 lines.
- R2: The vertical pre-sync code `vpre_sel` selects P lines at the end of the frame: 0→0, 1→1, 2→2, 3→4, 4→6, 5→8, 6→10, 7→12. A line with index ≥ F−P is masked, where F is the line count of the previous frame.
- R3: The pixel index is the number of clock cycles since the HSYNC active edge, and the edge cycle is index 0. Pixels with index < 2·`hpost_n` are masked.
- R4: Pixels with index ≥ L−2·`hpre_n` are masked, where L is the number of clock cycles between the two previous HSYNC active edges.
- R5: A value of 0 on `hpost_n` or `hpre_n` behaves exactly like a value of 1.
- R6: An active edge is the cycle in which a sync input first reaches its active level. Polarity 1 means active high and polarity 0 means active low.
- R7: `collect` equals `pix_valid` AND NOT any active mask, registered, so it appears one clock after the pixel. `pix_valid` low always gives `collect` low.
- R8: `collect` stays low during reset and until both trackers are locked. That takes two VSYNC active edges and two HSYNC active edges.
- R9: Line and frame lengths are measured again at every active edge, so a change in frame length moves the pre-sync line mask from the next frame onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | Current pixel carries data |
| hsync | input | 1 | Horizontal sync level |
| vsync | input | 1 | Vertical sync level |
| hsync_pol | input | 1 | 1: hsync active high, 0: active low |
| vsync_pol | input | 1 | 1: vsync active high, 0: active low |
| vpost_sel | input | 3 | Code for lines masked after the VSYNC edge |
| vpre_sel | input | 3 | Code for lines masked before the VSYNC edge |
| hpost_n | input | 8 | Pixel pairs masked after the HSYNC edge |
| hpre_n | input | 8 | Pixel pairs masked before the HSYNC edge |
| collect | output | 1 | Registered collect qualifier |

## Verification
The bench sweeps all eight codes of both vertical tables, both polarities on each sync, and zero values on each horizontal mask. A wrong table entry or a polarity mix-up shows up as the wrong count of collected lines per frame, or as collection running over the sync pulse. A frame-length change checks that the pre-sync mask follows the frame measured last: a design that kept its first measurement would mask the wrong tail lines, and one that used the current frame's count could not know it in time. The unlocked first frame, a long reset and a stretch with `pix_valid` held low check that collection cannot start early or leak out while data is invalid. A design with an off-by-one in the pixel index or in the captured length would show single-pixel miscompares at the window edges.

// File: rtl/vmask_pkg.sv
package vmask_pkg;

    typedef enum logic [1:0] {
        TRK_IDLE   = 2'd0,
        TRK_FIRST  = 2'd1,
        TRK_LOCKED = 2'd2
    } trk_state_e;

    // Lines hidden after the vertical sync edge, by code
    function automatic logic [5:0] post_lines(input logic [2:0] code);
        logic [5:0] n;
        unique case (code)
            3'd0: n = 6'd5;
            3'd1: n = 6'd18;
            3'd2: n = 6'd19;
            3'd3: n = 6'd20;
            3'd4: n = 6'd22;
            3'd5: n = 6'd25;
            3'd6: n = 6'd41;
            default: n = 6'd44;
        endcase
        return n;
    endfunction

    // Lines hidden before the next vertical sync edge, by code
    function automatic logic [3:0] pre_lines(input logic [2:0] code);
        logic [3:0] n;
        unique case (code)
            3'd0: n = 4'd0;
            3'd1: n = 4'd1;
            3'd2: n = 4'd2;
            3'd3: n = 4'd4;
            3'd4: n = 4'd6;
            3'd5: n = 4'd8;
            3'd6: n = 4'd10;
            default: n = 4'd12;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/vmask_edge.sv
module vmask_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    input  logic pol_i,
    output logic edge_o
);
    logic act;
    logic act_q;

    assign act = pol_i ? sig_i : ~sig_i;

    always_ff @(posedge clk) begin
        if (!rst_n) act_q <= 1'b0;
        else        act_q <= act;
    end

    assign edge_o = act & ~act_q;

    // R6: an edge is a single-cycle event
    a_r6_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> !edge_o);

endmodule

// File: rtl/vmask_span.sv
module vmask_span
    import vmask_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic             step_i,
    output logic [CNT_W-1:0] pos_o,
    output logic [CNT_W-1:0] len_o,
    output logic             locked_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    trk_state_e       state, state_nxt;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   sum;
    logic [CNT_W-1:0] sum_sat;
    logic [CNT_W-1:0] len_q;

    assign sum     = {1'b0, cnt} + {{CNT_W{1'b0}}, step_i};
    assign sum_sat = sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= TRK_IDLE;
        else        state <= state_nxt;
    end

    // transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            TRK_IDLE:   if (restart_i) state_nxt = TRK_FIRST;
            TRK_FIRST:  if (restart_i) state_nxt = TRK_LOCKED;
            TRK_LOCKED: state_nxt = TRK_LOCKED;
            default:    state_nxt = TRK_IDLE;
        endcase
    end

    // position counter: index of the current unit within the interval
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt <= '0;
        else if (restart_i) cnt <= '0;
        else                cnt <= sum_sat;
    end

    // interval length, captured when an interval closes
    always_ff @(posedge clk) begin
        if (!rst_n)                              len_q <= '0;
        else if (restart_i && state != TRK_IDLE) len_q <= sum_sat;
    end

    // outputs
    always_comb begin
        pos_o    = restart_i ? '0 : sum_sat;
        len_o    = len_q;
        locked_o = (state == TRK_LOCKED);
    end

    // R8: once locked, the tracker never falls back
    a_r8_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        locked_o |=> locked_o);

    // R8: locking takes a second edge after the first
    a_r8_lock_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TRK_FIRST && !restart_i) |=> !locked_o);

endmodule

// File: rtl/vmask_window.sv
module vmask_window
    import vmask_pkg::*;
#(
    parameter int PIX_W   = 12,
    parameter int LINE_W  = 11,
    parameter int HMASK_W = 8
) (
    input  logic               pix_valid,
    input  logic [PIX_W-1:0]   hpos,
    input  logic [PIX_W-1:0]   hlen,
    input  logic               h_locked,
    input  logic [LINE_W-1:0]  vpos,
    input  logic [LINE_W-1:0]  vlen,
    input  logic               v_locked,
    input  logic [2:0]         vpost_sel,
    input  logic [2:0]         vpre_sel,
    input  logic [HMASK_W-1:0] hpost_n,
    input  logic [HMASK_W-1:0] hpre_n,
    output logic               collect_d
);
    localparam int HW = ((PIX_W > HMASK_W + 1) ? PIX_W : HMASK_W + 1) + 1;
    localparam int VW = ((LINE_W > 6) ? LINE_W : 6) + 1;

    logic [HMASK_W-1:0] hpost_eff, hpre_eff;
    logic [HW-1:0]      hpost_px, hpre_px, hpos_x, hlen_x;
    logic [VW-1:0]      vpost_x, vpre_x, vpos_x, vlen_x;
    logic               m_hpost, m_hpre, m_vpost, m_vpre;

    always_comb begin
        // R5: zero behaves as one
        hpost_eff = (hpost_n == '0) ? HMASK_W'(1) : hpost_n;
        hpre_eff  = (hpre_n  == '0) ? HMASK_W'(1) : hpre_n;
        hpost_px  = HW'({hpost_eff, 1'b0});
        hpre_px   = HW'({hpre_eff, 1'b0});
        hpos_x    = HW'(hpos);
        hlen_x    = HW'(hlen);
        vpost_x   = VW'(post_lines(vpost_sel));
        vpre_x    = VW'(pre_lines(vpre_sel));
        vpos_x    = VW'(vpos);
        vlen_x    = VW'(vlen);

        m_hpost = hpos_x < hpost_px;
        m_hpre  = h_locked && ((hpos_x + hpre_px) >= hlen_x);
        m_vpost = vpos_x < vpost_x;
        m_vpre  = v_locked && ((vpos_x + vpre_x) >= vlen_x);

        collect_d = pix_valid && h_locked && v_locked &&
                    !(m_hpost || m_hpre || m_vpost || m_vpre);
    end

endmodule

// File: rtl/vmask_top.sv
module vmask_top
    import vmask_pkg::*;
#(
    parameter int PIX_W   = 12,
    parameter int LINE_W  = 11,
    parameter int HMASK_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pix_valid,
    input  logic               hsync,
    input  logic               vsync,
    input  logic               hsync_pol,
    input  logic               vsync_pol,
    input  logic [2:0]         vpost_sel,
    input  logic [2:0]         vpre_sel,
    input  logic [HMASK_W-1:0] hpost_n,
    input  logic [HMASK_W-1:0] hpre_n,
    output logic               collect
);
    logic              hs_edge, vs_edge;
    logic [PIX_W-1:0]  hpos, hlen;
    logic [LINE_W-1:0] vpos, vlen;
    logic              h_locked, v_locked;
    logic              collect_d;
    logic              collect_q;

    vmask_edge u_hedge (
        .clk(clk), .rst_n(rst_n), .sig_i(hsync), .pol_i(hsync_pol), .edge_o(hs_edge)
    );

    vmask_edge u_vedge (
        .clk(clk), .rst_n(rst_n), .sig_i(vsync), .pol_i(vsync_pol), .edge_o(vs_edge)
    );

    // pixel position within the line; every clock is one pixel slot
    vmask_span #(.CNT_W(PIX_W)) u_hspan (
        .clk(clk), .rst_n(rst_n), .restart_i(hs_edge), .step_i(1'b1),
        .pos_o(hpos), .len_o(hlen), .locked_o(h_locked)
    );

    // line position within the frame; advances on each line start
    vmask_span #(.CNT_W(LINE_W)) u_vspan (
        .clk(clk), .rst_n(rst_n), .restart_i(vs_edge), .step_i(hs_edge),
        .pos_o(vpos), .len_o(vlen), .locked_o(v_locked)
    );

    vmask_window #(.PIX_W(PIX_W), .LINE_W(LINE_W), .HMASK_W(HMASK_W)) u_win (
        .pix_valid(pix_valid),
        .hpos(hpos), .hlen(hlen), .h_locked(h_locked),
        .vpos(vpos), .vlen(vlen), .v_locked(v_locked),
        .vpost_sel(vpost_sel), .vpre_sel(vpre_sel),
        .hpost_n(hpost_n), .hpre_n(hpre_n),
        .collect_d(collect_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) collect_q <= 1'b0;
        else        collect_q <= collect_d;
    end

    assign collect = collect_q;

    // R7: no data, no collection
    a_r7_valid_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> !collect);

    // R8: nothing is collected before both trackers lock
    a_r8_unlocked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(h_locked && v_locked) |=> !collect);

    // R3: the HSYNC edge pixel is always hidden
    a_r3_hedge_hidden: assert property (@(posedge clk) disable iff (!rst_n)
        hs_edge |=> !collect);

    // R1: the first line of a frame is always hidden
    a_r1_vedge_hidden: assert property (@(posedge clk) disable iff (!rst_n)
        vs_edge |=> !collect);

endmodule

// File: tb/sim_vmask_top.sv
module sim_vmask_top;
    localparam int CLK_PERIOD = 10;
    localparam int LL = 40;
    localparam int FL = 64;
    localparam int NV = 8;

    // {vpost code, vpre code, hpost, hpre, hpol, vpol, expected lines per locked frame}
    localparam logic [31:0] VECS [NV] = '{
        {3'd0, 3'd1, 8'd1, 8'd1, 1'b1, 1'b1, 8'd58},
        {3'd7, 3'd7, 8'd3, 8'd2, 1'b0, 1'b0, 8'd8},
        {3'd1, 3'd0, 8'd0, 8'd4, 1'b1, 1'b0, 8'd46},
        {3'd2, 3'd2, 8'd5, 8'd0, 1'b0, 1'b1, 8'd43},
        {3'd3, 3'd3, 8'd2, 8'd3, 1'b1, 1'b1, 8'd40},
        {3'd4, 3'd4, 8'd6, 8'd6, 1'b0, 1'b0, 8'd36},
        {3'd5, 3'd5, 8'd1, 8'd8, 1'b1, 1'b0, 8'd31},
        {3'd6, 3'd6, 8'd4, 8'd1, 1'b0, 1'b1, 8'd13}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pix_valid = 1'b0;
    logic hsync = 1'b0;
    logic vsync = 1'b0;
    logic hsync_pol = 1'b1;
    logic vsync_pol = 1'b1;
    logic [2:0] vpost_sel = '0;
    logic [2:0] vpre_sel = '0;
    logic [7:0] hpost_n = 8'd1;
    logic [7:0] hpre_n = 8'd1;
    logic collect;

    int nchk = 0;
    int nfail = 0;
    int vp, vr, h1e, h2e;
    bit pv_off = 1'b0;
    bit pend = 1'b0;
    bit pend_exp;
    int pend_f, pend_l;
    int mism;
    int lhits [8];
    int last_key;

    always #(CLK_PERIOD/2) clk = ~clk;

    vmask_top u0 (
        .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid),
        .hsync(hsync), .vsync(vsync), .hsync_pol(hsync_pol), .vsync_pol(vsync_pol),
        .vpost_sel(vpost_sel), .vpre_sel(vpre_sel),
        .hpost_n(hpost_n), .hpre_n(hpre_n), .collect(collect)
    );

    function automatic int post_of(input logic [2:0] c);
        case (c)
            3'd0: return 5;   3'd1: return 18; 3'd2: return 19; 3'd3: return 20;
            3'd4: return 22;  3'd5: return 25; 3'd6: return 41; default: return 44;
        endcase
    endfunction

    function automatic int pre_of(input logic [2:0] c);
        case (c)
            3'd0: return 0; 3'd1: return 1;  3'd2: return 2;  3'd3: return 4;
            3'd4: return 6; 3'd5: return 8;  3'd6: return 10; default: return 12;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive_idle();
        hsync = ~hsync_pol;
        vsync = ~vsync_pol;
        pix_valid = 1'b0;
    endtask

    // Compare the pixel driven one cycle earlier (R7 latency)
    task automatic cmp_pending();
        if (pend) begin
            if (collect !== pend_exp) mism++;
            if (collect === 1'b1 && (pend_f * 1024 + pend_l) != last_key) begin
                last_key = pend_f * 1024 + pend_l;
                lhits[pend_f]++;
            end
        end
    endtask

    task automatic setup(input logic [2:0] vps, input logic [2:0] vrs,
                         input logic [7:0] h1, input logic [7:0] h2,
                         input logic hp, input logic vpl);
        vpost_sel = vps; vpre_sel = vrs; hpost_n = h1; hpre_n = h2;
        hsync_pol = hp; vsync_pol = vpl;
        vp = post_of(vps); vr = pre_of(vrs);
        h1e = (h1 == 0) ? 1 : int'(h1);   // R5
        h2e = (h2 == 0) ? 1 : int'(h2);
        pend = 1'b0; pv_off = 1'b0; mism = 0; last_key = -1;
        for (int i = 0; i < 8; i++) lhits[i] = 0;
        @(negedge clk);
        rst_n = 1'b0;
        drive_idle();
        repeat (3) @(negedge clk);
        check(collect === 1'b0, "R8 reset", int'(collect), 0);
        rst_n = 1'b1;
    endtask

    task automatic run_frame(input int f, input int fl, input int prev_fl);
        for (int l = 0; l < fl; l++) begin
            for (int p = 0; p < LL; p++) begin
                @(negedge clk);
                cmp_pending();
                hsync = (p < 4) ? hsync_pol : ~hsync_pol;
                vsync = (l < 3) ? vsync_pol : ~vsync_pol;
                pix_valid = !pv_off && (((l * 3 + p) % 7) != 0);
                pend = 1'b1; pend_f = f; pend_l = l;
                pend_exp = (f >= 1) && pix_valid &&
                           (p >= 2 * h1e) && (p < LL - 2 * h2e) &&
                           (l >= vp) && (l < prev_fl - vr);
            end
        end
    endtask

    task automatic flush();
        @(negedge clk);
        cmp_pending();
        pend = 1'b0;
        drive_idle();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        drive_idle();
        repeat (4) @(negedge clk);
        check(collect === 1'b0, "R8 initial reset", int'(collect), 0);

        // Table walk: every vertical code, both polarities, zero horizontal values
        for (int v = 0; v < NV; v++) begin
            setup(VECS[v][31:29], VECS[v][28:26], VECS[v][25:18], VECS[v][17:10],
                  VECS[v][9], VECS[v][8]);
            run_frame(0, FL, FL);
            run_frame(1, FL, FL);
            run_frame(2, FL, FL);
            flush();
            check(lhits[0] == 0, "R8 unlocked frame", lhits[0], 0);
            check(lhits[1] == int'(VECS[v][7:0]), "R1 R2 lines frame1", lhits[1], int'(VECS[v][7:0]));
            check(lhits[2] == int'(VECS[v][7:0]), "R1 R2 lines frame2", lhits[2], int'(VECS[v][7:0]));
            check(mism == 0, "R3 R4 R5 R6 R7 per-pixel", mism, 0);
        end

        // R9: frame shortens from 64 to 60 lines
        setup(3'd0, 3'd3, 8'd2, 8'd2, 1'b1, 1'b1);
        run_frame(0, 64, 64);
        run_frame(1, 64, 64);
        run_frame(2, 60, 64);
        run_frame(3, 60, 60);
        flush();
        check(lhits[2] == 55, "R9 first short frame", lhits[2], 55);
        check(lhits[3] == 51, "R9 second short frame", lhits[3], 51);
        check(mism == 0, "R9 per-pixel", mism, 0);

        // R7: data invalid for a whole locked frame
        setup(3'd0, 3'd0, 8'd1, 8'd1, 1'b1, 1'b1);
        run_frame(0, FL, FL);
        pv_off = 1'b1;
        run_frame(1, FL, FL);
        flush();
        check(lhits[1] == 0, "R7 invalid pixels", lhits[1], 0);
        check(mism == 0, "R7 per-pixel", mism, 0);

        // R8: reset in the middle of a locked frame clears collection
        setup(3'd0, 3'd0, 8'd1, 8'd1, 1'b1, 1'b1);
        run_frame(0, FL, FL);
        run_frame(1, 20, FL);
        flush();
        check(lhits[1] > 0, "R8 collecting before reset", lhits[1], 15);
        rst_n = 1'b0;
        @(negedge clk);
        check(collect === 1'b0, "R8 mid-frame reset", int'(collect), 0);
        rst_n = 1'b1;

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule